// File: doc/BRIEF.md
# Speculative-Write FIFO with Commit and Discard

This block is a single-clock first-in first-out buffer whose producer can place a run of words into storage tentatively. The words sit behind the reader's view until the producer confirms them with a commit pulse, and then all of them appear at once. If the producer decides the run is bad, a discard pulse throws away every unconfirmed word in one cycle and gives their slots back. Typical use is a packet receiver that writes a frame while its check sequence is still being computed, then keeps or drops the whole frame.

Two write positions are tracked. One marks the end of confirmed data, and the reader compares against it. The other marks the end of everything written, and the full flag and the free-slot count come from it. The read side presents the oldest visible word on its data output without a request, and a read enable pops that word. DEPTH must be a power of two, at least 2.

Top module: `spec_commit_fifo`

## Requirements
- R1: After reset, `rd_empty`=1, `wr_full`=0, `size`=0 and `space`=DEPTH.
- R2: An accepted write with neither commit nor discard does not change `size` or `rd_empty`. It lowers `space` by one.
- R3: A commit makes every pending unconfirmed word readable, and this includes a word written in the same cycle. `size` shows them after the next clock edge.
- R4: A discard drops every pending unconfirmed word, and this includes a word presented in the same cycle. Afterwards `space` equals DEPTH minus `size`.
- R5: When commit and discard are high together, the discard behaviour of R4 applies and nothing is committed.
- R6: `space` equals DEPTH minus the number of confirmed-unread and unconfirmed words. `wr_full` is 1 exactly when `space` is 0.
- R7: A write while `wr_full`=1 is ignored. No word is stored or counted, and later reads never return it.
- R8: A read while `rd_empty`=1 is ignored. `size` stays 0 and no later word is skipped.
- R9: `rd_data` shows the oldest confirmed word, and words leave in the order they were written.
- R10: `size` equals the number of confirmed words not yet read, and `rd_empty` is 1 exactly when `size` is 0.
- R11: A read and a write with commit in the same cycle both take effect. `size` is unchanged when one word leaves and one arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_data | input | DATA_W | Word to store |
| wr_en | input | 1 | Write request |
| wr_commit | input | 1 | Make all pending words readable |
| wr_discard | input | 1 | Drop all pending words |
| wr_full | output | 1 | No free slot; writes are ignored |
| rd_data | output | DATA_W | Oldest readable word |
| rd_en | input | 1 | Pop the oldest readable word |
| rd_empty | output | 1 | No readable word; reads are ignored |
| size | output | $clog2(DEPTH+1) | Readable word count |
| space | output | $clog2(DEPTH+1) | Free slot count |

## Verification
A corrupted confirmed pointer shows up in `size` on the next cycle. It can also show as a shifted or repeated `rd_data` word at the next pop. A corrupted tentative pointer shows up in `space` or `wr_full` at once. It can also show later, as a missing word or a dropped frame that reappears after a commit. The bench compares all four counters and flags against an arithmetic queue model after every clock edge, so any such fault is reported within one cycle of the stimulus that exposes it.

// File: rtl/scf_pkg.sv
package scf_pkg;

    // Action taken on the write side in a cycle, after priority resolution
    typedef enum logic [1:0] {
        WA_HOLD   = 2'd0,
        WA_COMMIT = 2'd1,
        WA_DROP   = 2'd2
    } wr_act_e;

    // Discard outranks commit
    function automatic wr_act_e resolve_act(input logic commit, input logic discard);
        if (discard)     return WA_DROP;
        else if (commit) return WA_COMMIT;
        else             return WA_HOLD;
    endfunction

endpackage

// File: rtl/scf_wr_ctrl.sv
module scf_wr_ctrl #(
    parameter int DEPTH = 16,
    parameter int PTR_W = 5,
    parameter int CNT_W = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  scf_pkg::wr_act_e     act,
    input  logic [PTR_W-1:0]     rd_ptr,
    output logic [PTR_W-1:0]     spec_ptr,
    output logic [PTR_W-1:0]     com_ptr,
    output logic                 wr_accept,
    output logic                 full,
    output logic [CNT_W-1:0]     space
);
    import scf_pkg::*;

    logic [PTR_W-1:0] used;
    logic [PTR_W-1:0] spec_adv;

    assign used      = spec_ptr - rd_ptr;
    assign full      = (used == PTR_W'(DEPTH));
    assign space     = CNT_W'(PTR_W'(DEPTH) - used);
    assign wr_accept = wr_en && !full;
    assign spec_adv  = spec_ptr + PTR_W'(wr_accept);

    always_ff @(posedge clk) begin
        if (rst) begin
            spec_ptr <= '0;
            com_ptr  <= '0;
        end else begin
            unique case (act)
                WA_DROP: begin
                    spec_ptr <= com_ptr;
                end
                WA_COMMIT: begin
                    spec_ptr <= spec_adv;
                    com_ptr  <= spec_adv;
                end
                default: begin
                    spec_ptr <= spec_adv;
                end
            endcase
        end
    end
endmodule

// File: rtl/scf_rd_ctrl.sv
module scf_rd_ctrl #(
    parameter int PTR_W = 5,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [PTR_W-1:0] com_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             empty,
    output logic [CNT_W-1:0] size
);
    logic [PTR_W-1:0] avail;

    assign avail = com_ptr - rd_ptr;
    assign empty = (avail == '0);
    assign size  = CNT_W'(avail);

    always_ff @(posedge clk) begin
        if (rst)               rd_ptr <= '0;
        else if (rd_en && !empty) rd_ptr <= rd_ptr + PTR_W'(1);
    end
endmodule

// File: rtl/scf_store.sv
module scf_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/spec_commit_fifo.sv
module spec_commit_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    input  logic              wr_commit,
    input  logic              wr_discard,
    output logic              wr_full,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rd_en,
    output logic              rd_empty,
    output logic [CNT_W-1:0]  size,
    output logic [CNT_W-1:0]  space
);
    import scf_pkg::*;

    wr_act_e          act;
    logic [PTR_W-1:0] spec_ptr, com_ptr, rd_ptr;
    logic             wr_accept;
    logic             store_we;

    assign act      = resolve_act(wr_commit, wr_discard);
    // A word dropped in its own cycle never needs a slot
    assign store_we = wr_accept && (act != WA_DROP);

    scf_wr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_wr (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .act       (act),
        .rd_ptr    (rd_ptr),
        .spec_ptr  (spec_ptr),
        .com_ptr   (com_ptr),
        .wr_accept (wr_accept),
        .full      (wr_full),
        .space     (space)
    );

    scf_rd_ctrl #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .com_ptr (com_ptr),
        .rd_ptr  (rd_ptr),
        .empty   (rd_empty),
        .size    (size)
    );

    scf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (store_we),
        .waddr (spec_ptr[ADDR_W-1:0]),
        .wdata (wr_data),
        .raddr (rd_ptr[ADDR_W-1:0]),
        .rdata (rd_data)
    );
endmodule

// File: rtl/scf_checker.sv
module scf_checker #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              wr_commit,
    input logic              wr_discard,
    input logic              wr_full,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_en,
    input logic              rd_empty,
    input logic [CNT_W-1:0]  size,
    input logic [CNT_W-1:0]  space
);
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
        (32'(size) + 32'(space)) <= DEPTH); // R6

    AST_FULL_MATCH: assert property (@(posedge clk) disable iff (rst)
        wr_full == (space == '0)); // R6

    AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (rst)
        rd_empty == (size == '0)); // R10

    AST_HIDDEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!wr_commit && !rd_en) |=> (size == $past(size))); // R2

    AST_DISCARD_RECLAIM: assert property (@(posedge clk) disable iff (rst)
        wr_discard |=> (32'(space) == DEPTH - 32'(size))); // R4

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_full && !rd_en && !wr_discard) |=> wr_full); // R7

    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_empty && !wr_commit) |=> rd_empty); // R8

    AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!rd_empty && !rd_en) |=> $stable(rd_data)); // R9

    AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_commit && !wr_discard && wr_en && !wr_full && !rd_en) |=> (size > $past(size))); // R3
endmodule

bind spec_commit_fifo scf_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_commit  (wr_commit),
    .wr_discard (wr_discard),
    .wr_full    (wr_full),
    .rd_data    (rd_data),
    .rd_en      (rd_en),
    .rd_empty   (rd_empty),
    .size       (size),
    .space      (space)
);

// File: tb/tb_spec_commit_fifo.sv
`timescale 1ns/1ps
module tb_spec_commit_fifo;
    localparam int DW    = 8;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          wr_en = 1'b0, wr_commit = 1'b0, wr_discard = 1'b0, rd_en = 1'b0;
    logic          wr_full, rd_empty;
    logic [DW-1:0] rd_data;
    logic [CW-1:0] size, space;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [DW-1:0] vis[$];
    logic [DW-1:0] pend[$];

    always #2.5 clk = ~clk;

    spec_commit_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_en(wr_en),
        .wr_commit(wr_commit), .wr_discard(wr_discard), .wr_full(wr_full),
        .rd_data(rd_data), .rd_en(rd_en), .rd_empty(rd_empty),
        .size(size), .space(space)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compare every port against the queue model
    task automatic cmp_model();
        int occ;
        occ = vis.size() + pend.size();
        chk("R10 size", int'(size), vis.size());
        chk("R10 empty", int'(rd_empty), int'(vis.size() == 0));
        chk("R6 space", int'(space), DEPTH - occ);
        chk("R6 full", int'(wr_full), int'(occ == DEPTH));
        if (vis.size() > 0) chk("R9 head", int'(rd_data), int'(vis[0]));
    endtask

    // Drive one cycle from a negative edge, update model, compare at next negative edge
    task automatic step(input logic we, input logic [DW-1:0] d, input logic cm,
                        input logic ds, input logic re);
        bit aw, ar;
        wr_en = we; wr_data = d; wr_commit = cm; wr_discard = ds; rd_en = re;
        aw = we && ((vis.size() + pend.size()) < DEPTH);
        ar = re && (vis.size() > 0);
        @(posedge clk);
        if (ar) void'(vis.pop_front());
        if (aw) pend.push_back(d);
        if (ds) pend.delete();
        else if (cm) begin
            foreach (pend[i]) vis.push_back(pend[i]);
            pend.delete();
        end
        @(negedge clk);
        wr_en = 1'b0; wr_commit = 1'b0; wr_discard = 1'b0; rd_en = 1'b0;
        cmp_model();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 empty", int'(rd_empty), 1);
        chk("R1 full", int'(wr_full), 0);
        chk("R1 size", int'(size), 0);
        chk("R1 space", int'(space), DEPTH);

        // R2: pending words hidden
        step(1, 8'd10, 0, 0, 0);
        step(1, 8'd11, 0, 0, 0);
        step(1, 8'd12, 0, 0, 0);
        chk("R2 size", int'(size), 0);
        chk("R2 empty", int'(rd_empty), 1);
        chk("R2 space", int'(space), DEPTH - 3);

        // R3: commit includes the same-cycle word
        step(1, 8'd13, 1, 0, 0);
        chk("R3 size", int'(size), 4);
        chk("R3 head", int'(rd_data), 10);

        // R4: discard drops pending words and the same-cycle word
        step(1, 8'd20, 0, 0, 0);
        step(1, 8'd21, 0, 0, 0);
        step(1, 8'd22, 0, 1, 0);
        chk("R4 size", int'(size), 4);
        chk("R4 space", int'(space), DEPTH - 4);

        // R5: discard outranks commit
        step(1, 8'd30, 0, 0, 0);
        step(1, 8'd31, 1, 1, 0);
        chk("R5 size", int'(size), 4);
        chk("R5 space", int'(space), DEPTH - 4);

        // R9: order of delivery
        for (int k = 0; k < 4; k++) begin
            chk("R9 order", int'(rd_data), 10 + k);
            step(0, 8'd0, 0, 0, 1);
        end
        chk("R9 drained", int'(rd_empty), 1);

        // R8: read on empty ignored
        step(0, 8'd0, 0, 0, 1);
        chk("R8 size", int'(size), 0);
        step(1, 8'd77, 1, 0, 0);
        chk("R8 head", int'(rd_data), 77);
        step(0, 8'd0, 0, 0, 1);

        // R7: writes while full are ignored
        for (int k = 0; k < DEPTH; k++) step(1, 8'(40 + k), k == DEPTH - 1, 0, 0);
        chk("R7 full", int'(wr_full), 1);
        step(1, 8'd99, 1, 0, 0);
        chk("R7 size", int'(size), DEPTH);
        chk("R7 space", int'(space), 0);
        for (int k = 0; k < DEPTH; k++) begin
            chk("R7 order", int'(rd_data), 40 + k);
            step(0, 8'd0, 0, 0, 1);
        end
        chk("R7 no extra", int'(rd_empty), 1);

        // R11: simultaneous pop and committed push
        step(1, 8'd60, 1, 0, 0);
        step(1, 8'd61, 1, 0, 0);
        step(1, 8'd62, 1, 0, 1);
        chk("R11 size", int'(size), 2);
        chk("R11 head", int'(rd_data), 61);

        // Sweep: phases of low and high read pressure
        for (int ph = 0; ph < 16; ph++) begin
            int rp;
            rp = (ph % 2 == 0) ? 20 : 75;
            for (int c = 0; c < 2000; c++) begin
                int r;
                r = int'($urandom_range(0, 99));
                step($urandom_range(0, 99) < 65, 8'($urandom),
                     $urandom_range(0, 99) < 15, $urandom_range(0, 99) < 5,
                     r < rp);
            end
        end
        while (vis.size() > 0) step(0, 8'd0, 0, 0, 1);
        step(0, 8'd0, 0, 1, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule